// File: doc/BRIEF.md
# Packet Type Classifier and Bank Store

This block takes a stream of 32-bit packet words and decides where each packet belongs. Each word arrives with start and end markers. The first word of a packet also carries a 3-bit offset: the word index, counted from that start word, at which the payload begins. The word at that index is the tag word. A value of zero marks a program packet and a value of one marks a data packet.

Because the tag arrives several words after the packet starts, every word first goes through a short delay FIFO. A separate small queue holds the verdict for each packet. The store side does not release a packet until its verdict is known.

- **Program packets:** the payload words after the tag go into one of two program banks, and the two banks are used in turn.
- **Data packets:** every word of the packet, headers and trailer included, goes into one of four data banks. Each data bank has an occupancy flag that the consumer clears.
- **Other packets:** a packet with any other tag, or one that ends before its tag, is discarded.

The memories sit outside the block behind two simple write ports.

Top module: `pkt_sorter`

## Requirements
- R1: A packet is classified by the word at index `in_ofs` (0 to 7, counted from the start word as index 0). Tag 32'h00000000 makes it a program packet and 32'h00000001 makes it a data packet. In any cycle at most one of the two memory ports writes, and at most one of the two end-of-packet pulses fires.
- R2: For a program packet, only the words after the tag are written to the program port, at addresses 0, 1, 2 and so on. `new_prog` pulses for one cycle together with the last word of the packet, with `prog_bank` giving the bank just filled.
- R3: After reset, program packets alternate between program banks 0 and 1, starting with bank 0.
- R4: For a data packet, every word from the start word to the end word, tag included, is written in order at data addresses 0, 1, 2 and so on. `wr_grant` is high in every cycle that writes data memory.
- R5: A data packet goes to the first bank whose `bank_full` bit is clear, searching upward with wrap-around from the bank after the last one filled (bank 0 after reset). When the packet's last word is stored, `data_done` pulses with `done_bank`, and the bank's `bank_full` bit is set on the next cycle. A `rel_valid` pulse with `rel_bank` clears that bit.
- R6: A bank holds at most 64 words, and words beyond that are not written. For a data packet that overflowed, `data_trunc` is high in the same cycle as `data_done`.
- R7: A packet whose tag is neither value, or that ends before its tag word, causes no memory write and no pulse, and does not move any bank pointer.
- R8: `in_ready` is low whenever all four `bank_full` bits are set, and it returns high once one of them is released.
- R9: After reset, `in_ready` is high, `bank_full` is 0 and neither write port is active.
- R10: Idle cycles within a packet and packets sent back to back without a gap give the same memory contents as packets sent separately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_sop | input | 1 | First word of a packet |
| in_eop | input | 1 | Last word of a packet |
| in_ofs | input | 3 | Tag word index, sampled with the first word |
| in_data | input | 32 | Packet word |
| in_ready | output | 1 | Word accepted when high together with in_valid |
| rel_valid | input | 1 | Release one data bank |
| rel_bank | input | 2 | Data bank to release |
| pm_we | output | 1 | Program memory write enable |
| pm_bank | output | 1 | Program bank index |
| pm_addr | output | 6 | Program word address |
| pm_wdata | output | 32 | Program write data |
| dm_we | output | 1 | Data memory write enable |
| dm_bank | output | 2 | Data bank index |
| dm_addr | output | 6 | Data word address |
| dm_wdata | output | 32 | Data write data |
| wr_grant | output | 1 | High while a data packet is being stored |
| new_prog | output | 1 | One-cycle pulse when a program packet is complete |
| prog_bank | output | 1 | Program bank that was just filled |
| data_done | output | 1 | One-cycle pulse when a data packet is complete |
| done_bank | output | 2 | Data bank that was just filled |
| data_trunc | output | 1 | Data packet exceeded bank size, valid with data_done |
| bank_full | output | 4 | Occupancy flag per data bank |

## Verification
The bench aims at four corners.
- **Tag positions:** it puts the tag at offset 0, in a single-word packet, and at offset 7. A design that stalls for the verdict at the wrong word would write the tag into program memory, or would hang waiting for the FIFO.
- **Oversized and foreign packets:** 70-word packets probe the 64-word limit, where an off-by-one would overwrite address 0 or drop word 63. Packets with an unknown tag, or that end before the tag, must leave both the memories and the bank pointers alone.
- **Bank exhaustion:** the bench fills all four data banks and then frees one out of order. This checks that `in_ready` falls, and that the next data packet lands in the released bank rather than in the next one in rotation.
- **Streaming:** back-to-back packets of mixed types catch a verdict queue that pairs a verdict with the wrong packet.

// File: rtl/pkt_sorter_pkg.sv
// Shared types for the packet sorter.
// Assumes 32-bit words; kind codes are internal to the block.
package pkt_sorter_pkg;
    localparam int WORD_W = 32;
    localparam logic [WORD_W-1:0] TAG_PROG = 32'h0000_0000;
    localparam logic [WORD_W-1:0] TAG_DATA = 32'h0000_0001;

    typedef enum logic [1:0] {
        KIND_DROP = 2'd0,
        KIND_PROG = 2'd1,
        KIND_DATA = 2'd2
    } pkt_kind_e;

    typedef struct packed {
        logic              sop;
        logic              eop;
        logic              post;   // word lies after the tag word
        logic [WORD_W-1:0] data;
    } fifo_word_t;
endpackage

// File: rtl/sorter_fifo.sv
// Synchronous FIFO holding WIDTH-bit entries.
// Assumes DEPTH is a power of two and the caller never pushes when full
// or pops when empty.
module sorter_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wp, rp;

    assign empty = (wp == rp);
    assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign dout  = mem[rp[AW-1:0]];

    // Storage write, no reset needed on the array.
    always_ff @(posedge clk) begin
        if (push) mem[wp[AW-1:0]] <= din;
    end

    // Pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
        end
    end
endmodule

// File: rtl/sorter_classify.sv
// Input-side classifier: tracks the word index inside the current packet,
// marks words after the tag, and emits one kind verdict per packet.
// Assumes in_ofs is only meaningful on the start word.
module sorter_classify
    import pkt_sorter_pkg::*;
#(
    parameter int OFS_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              sop,
    input  logic              eop,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [WORD_W-1:0] data,
    output logic              post,
    output logic              kind_push,
    output pkt_kind_e         kind
);
    localparam logic [OFS_W:0] IDX_SAT = {1'b1, {OFS_W{1'b0}}};

    logic [OFS_W:0]   idx_q, cur_idx;
    logic [OFS_W-1:0] ofs_q, cur_ofs;
    logic             seen_q, seen, is_tag;

    // Current position and offset, taking a fresh packet start into account.
    always_comb begin
        cur_idx   = sop ? '0 : idx_q;
        cur_ofs   = sop ? ofs : ofs_q;
        seen      = sop ? 1'b0 : seen_q;
        is_tag    = acc && (cur_idx == {1'b0, cur_ofs});
        post      = cur_idx > {1'b0, cur_ofs};
        kind_push = is_tag || (acc && eop && !seen);
        if (is_tag && data == TAG_PROG)      kind = KIND_PROG;
        else if (is_tag && data == TAG_DATA) kind = KIND_DATA;
        else                                 kind = KIND_DROP;
    end

    // Per-packet index, offset and tag-seen tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            ofs_q  <= '0;
            seen_q <= 1'b0;
        end else if (acc) begin
            idx_q  <= (cur_idx == IDX_SAT) ? cur_idx : cur_idx + 1'b1;
            ofs_q  <= cur_ofs;
            seen_q <= seen || is_tag;
        end
    end
endmodule

// File: rtl/sorter_drain.sv
// Output side: waits for a packet's verdict, then streams its words into
// the program or data port, keeps bank pointers and occupancy flags.
// Assumes NDB and NPB are powers of two and the FIFO head is a start word
// whenever no packet is in progress.
module sorter_drain
    import pkt_sorter_pkg::*;
#(
    parameter int NDB      = 4,
    parameter int NPB      = 2,
    parameter int DB_WORDS = 64,
    parameter int PB_WORDS = 64,
    localparam int DBW = $clog2(NDB),
    localparam int PBW = $clog2(NPB),
    localparam int DAW = $clog2(DB_WORDS),
    localparam int PAW = $clog2(PB_WORDS),
    localparam int CW  = ((DAW > PAW) ? DAW : PAW) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wf_empty,
    input  fifo_word_t        wf_head,
    input  logic              tf_empty,
    input  pkt_kind_e         tf_head,
    input  logic              rel_valid,
    input  logic [DBW-1:0]    rel_bank,
    output logic              wf_pop,
    output logic              tf_pop,
    output logic              pm_we,
    output logic [PBW-1:0]    pm_bank,
    output logic [PAW-1:0]    pm_addr,
    output logic [WORD_W-1:0] pm_wdata,
    output logic              dm_we,
    output logic [DBW-1:0]    dm_bank,
    output logic [DAW-1:0]    dm_addr,
    output logic [WORD_W-1:0] dm_wdata,
    output logic              wr_grant,
    output logic              new_prog,
    output logic [PBW-1:0]    prog_bank,
    output logic              data_done,
    output logic [DBW-1:0]    done_bank,
    output logic              data_trunc,
    output logic [NDB-1:0]    bank_full
);
    logic            busy_q, trunc_q;
    pkt_kind_e       kind_q, cur_kind;
    logic [DBW-1:0]  dbank_q, cur_dbank, dptr, free_sel;
    logic [PBW-1:0]  pptr;
    logic [CW-1:0]   cnt_q, cnt;
    logic [NDB-1:0]  full_q;
    logic            any_free, start, elig_d, elig_p, lost, last, trunc_eff;

    // Rotating search for the first free data bank at or after the pointer.
    always_comb begin
        free_sel = dptr;
        any_free = 1'b0;
        for (int k = NDB - 1; k >= 0; k--) begin
            if (!full_q[dptr + DBW'(k)]) begin
                free_sel = dptr + DBW'(k);
                any_free = 1'b1;
            end
        end
    end

    // Packet start, pop control and write decode.
    always_comb begin
        start     = !busy_q && !wf_empty && wf_head.sop && !tf_empty &&
                    (tf_head != KIND_DATA || any_free);
        wf_pop    = !wf_empty && (busy_q || start);
        tf_pop    = start;
        cur_kind  = busy_q ? kind_q  : tf_head;
        cur_dbank = busy_q ? dbank_q : free_sel;
        cnt       = busy_q ? cnt_q   : '0;
        trunc_eff = busy_q && trunc_q;
        elig_d    = (cur_kind == KIND_DATA);
        elig_p    = (cur_kind == KIND_PROG) && wf_head.post;
        dm_we     = wf_pop && elig_d && (cnt < CW'(DB_WORDS));
        pm_we     = wf_pop && elig_p && (cnt < CW'(PB_WORDS));
        lost      = wf_pop && ((elig_d && !(cnt < CW'(DB_WORDS))) ||
                               (elig_p && !(cnt < CW'(PB_WORDS))));
        last      = wf_pop && wf_head.eop;
        data_done = last && elig_d;
        new_prog  = last && (cur_kind == KIND_PROG);
        data_trunc = data_done && (trunc_eff || lost);
        wr_grant  = (busy_q || start) && elig_d;
    end

    assign pm_bank   = pptr;
    assign pm_addr   = cnt[PAW-1:0];
    assign pm_wdata  = wf_head.data;
    assign dm_bank   = cur_dbank;
    assign dm_addr   = cnt[DAW-1:0];
    assign dm_wdata  = wf_head.data;
    assign prog_bank = pptr;
    assign done_bank = cur_dbank;
    assign bank_full = full_q;

    // Packet state, address counter and bank pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            trunc_q <= 1'b0;
            kind_q  <= KIND_DROP;
            dbank_q <= '0;
            cnt_q   <= '0;
            dptr    <= '0;
            pptr    <= '0;
        end else begin
            if (wf_pop) begin
                busy_q  <= !wf_head.eop;
                kind_q  <= cur_kind;
                dbank_q <= cur_dbank;
                cnt_q   <= (dm_we || pm_we) ? cnt + 1'b1 : cnt;
                trunc_q <= trunc_eff || lost;
            end
            if (data_done) dptr <= cur_dbank + 1'b1;
            if (new_prog)  pptr <= pptr + 1'b1;
        end
    end

    // Data bank occupancy: release first, a completed store wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= '0;
        end else begin
            if (rel_valid) full_q[rel_bank]  <= 1'b0;
            if (data_done) full_q[cur_dbank] <= 1'b1;
        end
    end
endmodule

// File: rtl/pkt_sorter.sv
// Top level: classifies each packet by its tag word and stores it into
// rotating program or data banks through two write ports.
// Assumes in_ofs < FIFO_DEPTH so the tag always fits in the delay FIFO.
module pkt_sorter
    import pkt_sorter_pkg::*;
#(
    parameter int NDB        = 4,
    parameter int NPB        = 2,
    parameter int DB_WORDS   = 64,
    parameter int PB_WORDS   = 64,
    parameter int FIFO_DEPTH = 8,
    parameter int OFS_W      = 3,
    localparam int DBW = $clog2(NDB),
    localparam int PBW = $clog2(NPB),
    localparam int DAW = $clog2(DB_WORDS),
    localparam int PAW = $clog2(PB_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [OFS_W-1:0]  in_ofs,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    input  logic              rel_valid,
    input  logic [DBW-1:0]    rel_bank,
    output logic              pm_we,
    output logic [PBW-1:0]    pm_bank,
    output logic [PAW-1:0]    pm_addr,
    output logic [WORD_W-1:0] pm_wdata,
    output logic              dm_we,
    output logic [DBW-1:0]    dm_bank,
    output logic [DAW-1:0]    dm_addr,
    output logic [WORD_W-1:0] dm_wdata,
    output logic              wr_grant,
    output logic              new_prog,
    output logic [PBW-1:0]    prog_bank,
    output logic              data_done,
    output logic [DBW-1:0]    done_bank,
    output logic              data_trunc,
    output logic [NDB-1:0]    bank_full
);
    localparam int EW = $bits(fifo_word_t);

    logic       acc, post, kind_push, wf_empty, wf_full, wf_pop;
    logic       tf_empty, tf_full, tf_pop;
    pkt_kind_e  kind;
    fifo_word_t wf_in, wf_head;
    logic [1:0] tf_raw;

    assign in_ready = !wf_full && !tf_full && !(&bank_full);
    assign acc      = in_valid && in_ready;
    assign wf_in    = '{sop: in_sop, eop: in_eop, post: post, data: in_data};

    sorter_classify #(.OFS_W(OFS_W)) u_cls (
        .clk(clk), .rst_n(rst_n), .acc(acc), .sop(in_sop), .eop(in_eop),
        .ofs(in_ofs), .data(in_data), .post(post),
        .kind_push(kind_push), .kind(kind)
    );

    sorter_fifo #(.WIDTH(EW), .DEPTH(FIFO_DEPTH)) u_word_q (
        .clk(clk), .rst_n(rst_n), .push(acc), .din(wf_in), .pop(wf_pop),
        .dout(wf_head), .empty(wf_empty), .full(wf_full)
    );

    sorter_fifo #(.WIDTH(2), .DEPTH(FIFO_DEPTH)) u_kind_q (
        .clk(clk), .rst_n(rst_n), .push(kind_push), .din(kind), .pop(tf_pop),
        .dout(tf_raw), .empty(tf_empty), .full(tf_full)
    );

    sorter_drain #(.NDB(NDB), .NPB(NPB), .DB_WORDS(DB_WORDS),
                   .PB_WORDS(PB_WORDS)) u_drain (
        .clk(clk), .rst_n(rst_n), .wf_empty(wf_empty), .wf_head(wf_head),
        .tf_empty(tf_empty), .tf_head(pkt_kind_e'(tf_raw)),
        .rel_valid(rel_valid), .rel_bank(rel_bank),
        .wf_pop(wf_pop), .tf_pop(tf_pop),
        .pm_we(pm_we), .pm_bank(pm_bank), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
        .dm_we(dm_we), .dm_bank(dm_bank), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
        .wr_grant(wr_grant), .new_prog(new_prog), .prog_bank(prog_bank),
        .data_done(data_done), .done_bank(done_bank), .data_trunc(data_trunc),
        .bank_full(bank_full)
    );
endmodule

// File: rtl/sorter_checks.sv
// Property checker bound to pkt_sorter; observes ports only.
module sorter_checks #(
    parameter int NDB = 4,
    parameter int PBW = 1,
    localparam int DBW = $clog2(NDB)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_ready,
    input logic           pm_we,
    input logic           dm_we,
    input logic           wr_grant,
    input logic           new_prog,
    input logic [PBW-1:0] prog_bank,
    input logic           data_done,
    input logic [DBW-1:0] done_bank,
    input logic           data_trunc,
    input logic [NDB-1:0] bank_full
);
    logic           np_seen;
    logic [PBW-1:0] np_last;

    // Remember the bank of the previous program completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            np_seen <= 1'b0;
            np_last <= '0;
        end else if (new_prog) begin
            np_seen <= 1'b1;
            np_last <= prog_bank;
        end
    end

    AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !(pm_we && dm_we)); // R1
    AST_ONE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(new_prog && data_done)); // R1
    AST_GRANT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we |-> wr_grant); // R4
    AST_FULL_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        data_done |=> bank_full[$past(done_bank)]); // R5
    AST_PROG_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        (new_prog && np_seen) |-> (prog_bank != np_last)); // R3
    AST_TRUNC_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        data_trunc |-> data_done); // R6
    AST_NO_ENTRY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (&bank_full) |-> !in_ready); // R8
endmodule

bind pkt_sorter sorter_checks #(.NDB(NDB), .PBW(PBW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .pm_we(pm_we),
    .dm_we(dm_we), .wr_grant(wr_grant), .new_prog(new_prog),
    .prog_bank(prog_bank), .data_done(data_done), .done_bank(done_bank),
    .data_trunc(data_trunc), .bank_full(bank_full)
);

// File: tb/pkt_sorter_tb_top.sv
// Bench: behavioural model builds expected write and event queues per
// packet; a monitor compares the design's ports against them every clock.
module pkt_sorter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [2:0]  in_ofs = '0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        rel_valid = 1'b0;
    logic [1:0]  rel_bank = '0;
    logic        pm_we, dm_we, wr_grant, new_prog, data_done, data_trunc;
    logic [0:0]  pm_bank, prog_bank;
    logic [5:0]  pm_addr, dm_addr;
    logic [31:0] pm_wdata, dm_wdata;
    logic [1:0]  dm_bank, done_bank;
    logic [3:0]  bank_full;

    always #10 clk = ~clk;

    pkt_sorter dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_ofs(in_ofs), .in_data(in_data), .in_ready(in_ready),
        .rel_valid(rel_valid), .rel_bank(rel_bank),
        .pm_we(pm_we), .pm_bank(pm_bank), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
        .dm_we(dm_we), .dm_bank(dm_bank), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
        .wr_grant(wr_grant), .new_prog(new_prog), .prog_bank(prog_bank),
        .data_done(data_done), .done_bank(done_bank), .data_trunc(data_trunc),
        .bank_full(bank_full)
    );

    // Memories living in bench scope.
    logic [31:0] pmem [2][64];
    logic [31:0] dmem [4][64];
    always @(posedge clk) begin
        if (pm_we) pmem[pm_bank][pm_addr] <= pm_wdata;
        if (dm_we) dmem[dm_bank][dm_addr] <= dm_wdata;
    end

    typedef struct { int bank; int addr; logic [31:0] d; } wr_t;
    typedef struct { int bank; bit tr; } dd_t;
    wr_t q_pm[$];
    wr_t q_dm[$];
    int  q_np[$];
    dd_t q_dd[$];

    int checks = 0, fails = 0, n_wr = 0;
    bit m_full[4];
    int m_dptr = 0, m_pptr = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] wordv(input int seed, input int i);
        return 32'(seed * 65536 + i);
    endfunction

    // Reference model: queue the writes and events one packet must cause.
    task automatic model_pkt(input logic [31:0] tag, input int ofs, input int len,
                             input int seed);
        int n = 0;
        if (len <= ofs) return;                            // R7 tag never seen
        if (tag == 32'h0) begin
            for (int i = ofs + 1; i < len; i++) begin
                if (n < 64) q_pm.push_back('{m_pptr, n, wordv(seed, i)});
                n++;
            end
            q_np.push_back(m_pptr);
            m_pptr = (m_pptr + 1) % 2;
        end else if (tag == 32'h1) begin
            int b = -1;
            for (int k = 0; k < 4; k++)
                if (b < 0 && !m_full[(m_dptr + k) % 4]) b = (m_dptr + k) % 4;
            for (int i = 0; i < len && i < 64; i++)
                q_dm.push_back('{b, i, (i == ofs) ? tag : wordv(seed, i)});
            q_dd.push_back('{b, len > 64});
            m_full[b] = 1'b1;
            m_dptr = (b + 1) % 4;
        end
    endtask

    task automatic send_pkt(input logic [31:0] tag, input int ofs, input int len,
                            input int seed, input bit gaps);
        model_pkt(tag, ofs, len, seed);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sop   = (i == 0);
            in_eop   = (i == len - 1);
            in_ofs   = 3'(ofs);
            in_data  = (i == ofs) ? tag : wordv(seed, i);
            while (!in_ready) @(negedge clk);
            if (gaps && i % 2 == 1 && i != len - 1) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eop   = 1'b0;
    endtask

    task automatic wait_idle();
        while (q_pm.size() + q_dm.size() + q_np.size() + q_dd.size() != 0)
            @(negedge clk);
        repeat (12) @(negedge clk);
    endtask

    task automatic release_bank(input int b);
        @(negedge clk);
        rel_valid = 1'b1;
        rel_bank  = 2'(b);
        @(negedge clk);
        rel_valid = 1'b0;
        m_full[b] = 1'b0;
    endtask

    // Monitor: compare every write and event against the model queues.
    always @(negedge clk) begin
        wr_t e;
        dd_t d;
        int  b;
        if (rst_n) begin
            if (pm_we) begin
                n_wr++;
                if (q_pm.size() == 0) chk(1'b0, "R2 unexpected program write", pm_addr, 0);
                else begin
                    e = q_pm.pop_front();
                    chk(pm_bank == 1'(e.bank), "R3 program bank", pm_bank, e.bank);
                    chk(pm_addr == 6'(e.addr), "R2 program address", pm_addr, e.addr);
                    chk(pm_wdata == e.d, "R2 program word", pm_wdata, e.d);
                end
            end
            if (dm_we) begin
                n_wr++;
                chk(wr_grant, "R4 grant during data write", wr_grant, 1);
                if (q_dm.size() == 0) chk(1'b0, "R4 unexpected data write", dm_addr, 0);
                else begin
                    e = q_dm.pop_front();
                    chk(dm_bank == 2'(e.bank), "R5 data bank", dm_bank, e.bank);
                    chk(dm_addr == 6'(e.addr), "R4 data address", dm_addr, e.addr);
                    chk(dm_wdata == e.d, "R4 data word", dm_wdata, e.d);
                end
            end
            if (new_prog) begin
                n_wr++;
                if (q_np.size() == 0) chk(1'b0, "R2 unexpected new_prog", prog_bank, 0);
                else if (q_pm.size() != 0) chk(1'b0, "R2 new_prog before last word", q_pm.size(), 0);
                else begin
                    b = q_np.pop_front();
                    chk(prog_bank == 1'(b), "R3 completed program bank", prog_bank, b);
                end
            end
            if (data_done) begin
                n_wr++;
                if (q_dd.size() == 0) chk(1'b0, "R5 unexpected data_done", done_bank, 0);
                else begin
                    d = q_dd.pop_front();
                    chk(done_bank == 2'(d.bank), "R5 done bank", done_bank, d.bank);
                    chk(data_trunc == d.tr, "R6 truncation flag", data_trunc, d.tr);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R9 ready after reset", in_ready, 1);
        chk(bank_full == 4'h0, "R9 banks empty after reset", bank_full, 0);
        chk(!pm_we && !dm_we, "R9 no write after reset", {pm_we, dm_we}, 0);

        // R1 R2 R3: program packets, two offsets, one with idle gaps (R10).
        send_pkt(32'h0, 2, 8, 1, 1'b0);
        wait_idle();
        send_pkt(32'h0, 0, 4, 2, 1'b1);
        wait_idle();

        // R4 R5: a plain data packet.
        send_pkt(32'h1, 3, 10, 3, 1'b0);
        wait_idle();
        chk(bank_full == 4'b0001, "R5 bank 0 marked full", bank_full, 4'b0001);

        // R7: foreign tag, and a packet ending before its tag.
        snap = n_wr;
        send_pkt(32'h7, 1, 6, 4, 1'b0);
        send_pkt(32'h0, 5, 3, 5, 1'b0);
        wait_idle();
        chk(n_wr == snap, "R7 dropped packets cause no writes", n_wr, snap);
        chk(bank_full == 4'b0001, "R7 bank flags untouched", bank_full, 4'b0001);

        // R6: oversized data packet.
        send_pkt(32'h1, 2, 70, 6, 1'b0);
        wait_idle();
        chk(dmem[1][63] == wordv(6, 63), "R6 last stored word", dmem[1][63], wordv(6, 63));

        // R10: back to back, tag at offset 7 and a single-word packet.
        send_pkt(32'h0, 7, 12, 7, 1'b0);
        send_pkt(32'h1, 1, 5, 8, 1'b0);
        send_pkt(32'h1, 0, 1, 9, 1'b0);
        wait_idle();
        chk(bank_full == 4'hF, "R5 all banks full", bank_full, 4'hF);
        chk(in_ready == 1'b0, "R8 ready low when all banks full", in_ready, 0);

        // R5 R8: release out of order, next data packet takes the freed bank.
        release_bank(2);
        chk(in_ready == 1'b1, "R8 ready back after release", in_ready, 1);
        chk(bank_full == 4'b1011, "R5 release clears flag", bank_full, 4'b1011);
        send_pkt(32'h1, 4, 9, 10, 1'b1);
        wait_idle();
        chk(in_ready == 1'b0, "R8 ready low again", in_ready, 0);

        // R6 on a program packet, then wrap-around bank search.
        release_bank(0);
        send_pkt(32'h0, 1, 70, 11, 1'b0);
        wait_idle();
        chk(pmem[1][63] == wordv(11, 65), "R6 program bank limit", pmem[1][63], wordv(11, 65));
        send_pkt(32'h1, 0, 6, 12, 1'b0);
        wait_idle();
        chk(bank_full == 4'hF, "R5 wrap to bank 0", bank_full, 4'hF);

        chk(q_pm.size() + q_dm.size() + q_np.size() + q_dd.size() == 0,
            "R4 all expected writes seen", q_pm.size() + q_dm.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule